// File: doc/BRIEF.md
# Burst Address Generator

This block sits in front of one port of a synchronous memory and produces the address that each access uses. On any cycle the port either presents an address from outside or lets an internal counter supply it. The counter can be loaded, held, advanced by one, or cleared to zero. Each of these actions is chosen on the rising edge of the port clock by three active-low controls, which follow a fixed priority. This allows long sequential reads or writes with only one address transfer at the start.

When the load strobe is low, the external address goes straight to the access in that same cycle and is also captured for later cycles. Otherwise the access uses the stored count. A clear does not insert a dead cycle: the access in the clear cycle still goes ahead. Counting does not depend on whether the memory port is selected. The counter covers the whole address space and rolls over from the top location to zero. A one-cycle rollover flag reports that wrap.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_ni is low, the counter is zero and wrap_o is low. Reset acts asynchronously.
- R2: When clr_ni is low at a rising edge, the counter becomes zero whatever ld_ni and cnt_en_ni are. The next cycle with ld_ni high accesses address zero.
- R3: A clear costs no dead cycle. During the clear cycle, acc_addr_o still shows that cycle's address: addr_i if ld_ni is low, otherwise the count held before the clear.
- R4: While ld_ni is low, acc_addr_o equals addr_i in the same cycle.
- R5: When ld_ni is low and clr_ni is high at a rising edge, addr_i is stored. A following cycle with ld_ni high accesses that stored address.
- R6: When cnt_en_ni is low and both ld_ni and clr_ni are high at a rising edge, the counter advances by one.
- R7: When ld_ni, cnt_en_ni and clr_ni are all high at a rising edge, the counter keeps its value and addr_i has no effect on it.
- R8: cnt_en_ni has no effect while ld_ni or clr_ni is low.
- R9: Advancing from the all-ones address gives zero.
- R10: wrap_o is high for exactly the one cycle after an edge where the counter advanced from all-ones to zero. A clear or a load does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Port clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | AW | External address |
| ld_ni | input | 1 | Active-low load strobe; selects addr_i for the access |
| cnt_en_ni | input | 1 | Active-low count enable |
| clr_ni | input | 1 | Active-low counter clear |
| acc_addr_o | output | AW | Address used by the current access |
| wrap_o | output | 1 | One-cycle rollover flag |

## Verification
The checker tests every cycle for the following, comparing each result with acc_addr_o on the next cycle that has ld_ni high:

- a clear leads to zero;
- a load leads to the loaded address, with the enable ignored;
- an advance adds one, modulo the address range;
- a hold keeps the address unchanged.

It also checks that wrap_o appears only after the all-ones count advanced.

Some behaviour can only be shown by the bench scenarios:

- the same-cycle passthrough during a clear;
- that addr_i is truly ignored while holding;
- the asynchronous reset in the middle of a run;
- the exact placement of the wrap pulse against clears and loads of zero.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_INC  = 2'd1,
    OP_LOAD = 2'd2,
    OP_CLR  = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/burst_op_dec.sv
module burst_op_dec
  import burst_addr_pkg::*;
(
  input  logic    ld_ni,
  input  logic    cnt_en_ni,
  input  logic    clr_ni,
  output cnt_op_e op_o
);
  // fixed priority: clear > load > advance > hold
  always_comb begin
    if (!clr_ni)         op_o = OP_CLR;
    else if (!ld_ni)     op_o = OP_LOAD;
    else if (!cnt_en_ni) op_o = OP_INC;
    else                 op_o = OP_HOLD;
  end
endmodule

// File: rtl/burst_cnt_reg.sv
module burst_cnt_reg
  import burst_addr_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  cnt_op_e       op_i,
  input  logic [AW-1:0] load_val_i,
  output logic [AW-1:0] cnt_o,
  output logic          wrap_o
);
  localparam logic [AW-1:0] CNT_MAX = {AW{1'b1}};

  logic [AW-1:0] cnt_q, cnt_d;
  logic          wrap_q, wrap_d;

  always_comb begin
    cnt_d  = cnt_q;
    wrap_d = 1'b0;
    unique case (op_i)
      OP_CLR:  cnt_d = '0;
      OP_LOAD: cnt_d = load_val_i;
      OP_INC: begin
        cnt_d  = cnt_q + 1'b1;
        wrap_d = (cnt_q == CNT_MAX);
      end
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wrap_q <= wrap_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap_q;
endmodule

// File: rtl/burst_addr_sel.sv
module burst_addr_sel #(
  parameter int AW = 16
) (
  input  logic          ld_ni,
  input  logic [AW-1:0] ext_addr_i,
  input  logic [AW-1:0] cnt_i,
  output logic [AW-1:0] acc_addr_o
);
  // load cycle passes the external address straight through
  assign acc_addr_o = ld_ni ? cnt_i : ext_addr_i;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          ld_ni,
  input  logic          cnt_en_ni,
  input  logic          clr_ni,
  output logic [AW-1:0] acc_addr_o,
  output logic          wrap_o
);
  cnt_op_e       op;
  logic [AW-1:0] cnt;

  burst_op_dec u_dec (
    .ld_ni     (ld_ni),
    .cnt_en_ni (cnt_en_ni),
    .clr_ni    (clr_ni),
    .op_o      (op)
  );

  burst_cnt_reg #(.AW(AW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op),
    .load_val_i (addr_i),
    .cnt_o      (cnt),
    .wrap_o     (wrap_o)
  );

  burst_addr_sel #(.AW(AW)) u_sel (
    .ld_ni      (ld_ni),
    .ext_addr_i (addr_i),
    .cnt_i      (cnt),
    .acc_addr_o (acc_addr_o)
  );
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic          ld_ni,
  input logic          cnt_en_ni,
  input logic          clr_ni,
  input logic [AW-1:0] acc_addr_o,
  input logic          wrap_o
);
  localparam logic [AW-1:0] ALL_ONES = {AW{1'b1}};

  p_clear_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> (!ld_ni || acc_addr_o == '0));

  // R8: enable ignored during load
  p_load_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && !ld_ni) |=> (!ld_ni || acc_addr_o == $past(addr_i)));

  p_pass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_ni |-> acc_addr_o == addr_i);

  // R9: modulo wrap included
  p_advance_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && ld_ni && !cnt_en_ni) |=>
      (!ld_ni || acc_addr_o == AW'($past(acc_addr_o) + 1'b1)));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && ld_ni && cnt_en_ni) |=> (!ld_ni || $stable(acc_addr_o)));

  p_wrap_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |-> $past(clr_ni && ld_ni && !cnt_en_ni && acc_addr_o == ALL_ONES));

  p_wrap_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_o && ld_ni) |-> acc_addr_o == '0);

  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!wrap_o && (!ld_ni || acc_addr_o == '0)));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .ld_ni      (ld_ni),
  .cnt_en_ni  (cnt_en_ni),
  .clr_ni     (clr_ni),
  .acc_addr_o (acc_addr_o),
  .wrap_o     (wrap_o)
);

// File: tb/sim_burst_addr_gen.sv
`timescale 1ns/1ps
module sim_burst_addr_gen;
  localparam int AW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          ld_ni = 1'b1;
  logic          cnt_en_ni = 1'b1;
  logic          clr_ni = 1'b1;
  logic [AW-1:0] acc_addr_o;
  logic          wrap_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  burst_addr_gen #(.AW(AW)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .ld_ni(ld_ni),
    .cnt_en_ni(cnt_en_ni), .clr_ni(clr_ni), .acc_addr_o(acc_addr_o),
    .wrap_o(wrap_o)
  );

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // apply controls after a falling edge, look at outputs 1 ns later
  task automatic drive(input logic ld, input logic en, input logic clr, input logic [AW-1:0] a);
    @(negedge clk_i);
    ld_ni = ld; cnt_en_ni = en; clr_ni = clr; addr_i = a;
    #1;
  endtask

  task automatic t_reset;
    drive(1, 1, 1, 16'h3C3C);
    chk("R1 acc", acc_addr_o, '0);
    chk("R1 wrap", AW'(wrap_o), '0);
  endtask

  task automatic t_load_hold;
    drive(0, 0, 1, 16'h1234);
    chk("R4 passthrough", acc_addr_o, 16'h1234);
    drive(1, 1, 1, 16'hFFFF);
    chk("R5/R8 loaded, enable ignored", acc_addr_o, 16'h1234);
    drive(1, 1, 1, 16'h0AAA);
    chk("R7 hold", acc_addr_o, 16'h1234);
    drive(1, 0, 1, 16'h0AAA);
    chk("R7 hold ignores addr_i", acc_addr_o, 16'h1234);
  endtask

  task automatic t_incr;
    drive(1, 0, 1, 16'h0000);
    chk("R6 advance 1", acc_addr_o, 16'h1235);
    drive(1, 1, 1, 16'h0000);
    chk("R6 advance 2", acc_addr_o, 16'h1236);
  endtask

  task automatic t_clear;
    drive(0, 0, 0, 16'h5555);
    chk("R3 clear cycle access", acc_addr_o, 16'h5555);
    drive(1, 0, 1, 16'h5555);
    chk("R2 cleared over load", acc_addr_o, 16'h0000);
    chk("R10 no wrap on clear", AW'(wrap_o), '0);
    drive(1, 1, 1, 16'h0);
    drive(1, 0, 0, 16'h0);
    chk("R3 clear cycle uses count", acc_addr_o, 16'h0001);
    drive(1, 1, 1, 16'h0);
    chk("R2/R8 clear beats enable", acc_addr_o, 16'h0000);
  endtask

  task automatic t_wrap;
    drive(0, 1, 1, 16'hFFFE);
    drive(1, 0, 1, 16'h0);
    chk("R6 loaded top-1", acc_addr_o, 16'hFFFE);
    drive(1, 0, 1, 16'h0);
    chk("R6 at top", acc_addr_o, 16'hFFFF);
    chk("R10 no early wrap", AW'(wrap_o), '0);
    drive(1, 1, 1, 16'h0);
    chk("R9 rolled to zero", acc_addr_o, 16'h0000);
    chk("R10 wrap pulse", AW'(wrap_o), 16'h0001);
    drive(0, 1, 1, 16'h0000);
    chk("R10 pulse one cycle", AW'(wrap_o), '0);
    drive(1, 1, 1, 16'h0);
    chk("R10 no wrap on zero load", AW'(wrap_o), '0);
  endtask

  task automatic t_async_reset;
    drive(0, 1, 1, 16'h0077);
    drive(1, 1, 1, 16'h0);
    chk("R5 load before reset", acc_addr_o, 16'h0077);
    #3 rst_ni = 1'b0;
    #1;
    chk("R1 async clear", acc_addr_o, 16'h0000);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_load_hold();
    t_incr();
    t_clear();
    t_wrap();
    t_async_reset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule